// File: doc/BRIEF.md
# Addressed SPI Slave Register File

This block is the peripheral end of a serial link with a fixed 9-bit address word. It holds a small bank of registers and serves a host that talks to it over SPI mode 0 (clock idles low). The serial pins are taken in through synchronizers and handled entirely in the system clock domain, so the system clock must run several times faster than the serial clock.

Reads and writes are framed differently. A read is one chip-select frame: the host sends a 9-bit address with the top bit set, keeps select low, and clocks out a data word whose length (8, 16 or 24 bits) depends on the register. A write takes two frames: a 9-bit address frame with the top bit clear, a select release, then a 9-bit data frame. A parallel port lets a bench or a neighbouring block load and inspect the registers directly.

Top module: `spi_regslave`

## Requirements
- R1: After reset every register reads zero on the parallel port, no write address is pending, and `spi_miso_oe` is low.
- R2: A frame whose first 9 bits have bit 8 set reads register index bits [7:0]; with select held, the register is returned MSB first on the following falling clock edges, 8 bits long for index mod 3 = 0, 16 for mod 3 = 1, 24 for mod 3 = 2.
- R3: A write frame pair (address frame with bit 8 clear, then a 9-bit data frame) stores the data zero-extended and masked to the register's length.
- R4: A pending write address is consumed by exactly the next frame; the frame after that is decoded as a fresh address.
- R5: A frame released after any bit count other than 9 (on an address or write-data frame) changes no register; if a write address was pending, it is dropped.
- R6: Indices at or above the register count read back as 8 zero bits, and writes to them change nothing.
- R7: `spi_miso_oe` is high exactly while the synchronized select is active.
- R8: `spi_miso` changes only after a falling serial clock edge or a select edge, so it is stable when the host samples on the rising edge.
- R9: A parallel-port write stores the data masked to the register's length, and the parallel read returns the register; a serial write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host, sampled on rising edge |
| spi_miso | output | 1 | Serial data to host, changed after falling edge |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| host_we | input | 1 | Parallel write strobe |
| host_idx | input | 8 | Parallel register index |
| host_wdata | input | 24 | Parallel write data |
| host_rdata | output | 24 | Parallel read data, zero for unmapped index |

## Verification
The hardest state to reach from the pins is a pending write address followed by a frame that ends early, since it needs a well-formed address frame, a release, then a truncated second frame, and the effect shows only in how the next frame is decoded. The bench builds this directly, then sends a read and confirms both the unchanged register and that the read was decoded as an address. Random sequences mix reads, write pairs and truncated frames of 1 to 8 and 10 to 12 bits over mapped and unmapped indices, so each read length and the dropped-pending path come up many times against the bench's register model.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int WORD_BITS = 9;
    localparam int REG_W     = 24;
    localparam int CNT_W     = 5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_SEND
    } phase_e;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [8:0] data;
    } wr_req_t;

    function automatic logic [CNT_W-1:0] read_len(input logic [7:0] idx, input int nregs);
        logic [7:0] m;
        if (int'(idx) >= nregs) return CNT_W'(8);
        m = idx % 8'd3;
        case (m)
            8'd0:    return CNT_W'(8);
            8'd1:    return CNT_W'(16);
            default: return CNT_W'(24);
        endcase
    endfunction

    function automatic logic [REG_W-1:0] len_mask(input logic [CNT_W-1:0] len);
        logic [REG_W:0] m;
        m = ((REG_W+1)'(1) << len) - (REG_W+1)'(1);
        return m[REG_W-1:0];
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int         N       = 3,
    parameter int         STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{RST_VAL[b]}};
            else     chain_q <= {chain_q[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             mosi_s,
    output logic [7:0]       rd_idx,
    input  logic [REG_W-1:0] rd_data,
    output wr_req_t          wr_req,
    output logic             miso,
    output logic             miso_oe
);
    logic             sclk_d, cs_n_d;
    logic             sclk_rise, sclk_fall, cs_start, cs_stop, sel_act;
    logic [8:0]       sh_q;
    logic [CNT_W-1:0] cnt_q;
    phase_e           ph_q;
    logic [REG_W-1:0] tx_q;
    logic             miso_q;
    logic             pend_q;
    logic [7:0]       pend_idx_q;
    wr_req_t          wr_q;
    logic [8:0]       full_word;
    logic [CNT_W-1:0] cur_len;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_start  = cs_n_d & ~cs_n_s;
    assign cs_stop   = ~cs_n_d & cs_n_s;
    assign sel_act   = ~cs_n_s;

    assign full_word = {sh_q[7:0], mosi_s};
    assign rd_idx    = full_word[7:0];
    assign cur_len   = read_len(rd_idx, NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            cs_n_d     <= 1'b1;
            sh_q       <= '0;
            cnt_q      <= '0;
            ph_q       <= PH_IDLE;
            tx_q       <= '0;
            miso_q     <= 1'b0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            wr_q       <= '0;
        end else begin
            sclk_d    <= sclk_s;
            cs_n_d    <= cs_n_s;
            wr_q.en   <= 1'b0;
            if (cs_start) begin
                cnt_q  <= '0;
                sh_q   <= '0;
                ph_q   <= PH_SHIFT;
                miso_q <= 1'b0;
            end else if (cs_stop) begin
                ph_q   <= PH_IDLE;
                miso_q <= 1'b0;
                if (ph_q == PH_SHIFT && cnt_q == CNT_W'(WORD_BITS)) begin
                    if (pend_q) begin
                        wr_q.en   <= 1'b1;
                        wr_q.idx  <= pend_idx_q;
                        wr_q.data <= sh_q;
                        pend_q    <= 1'b0;
                    end else if (!sh_q[8]) begin
                        pend_q     <= 1'b1;
                        pend_idx_q <= sh_q[7:0];
                    end
                end else begin
                    pend_q <= 1'b0;
                end
            end else if (sel_act) begin
                if (sclk_rise) begin
                    if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                    if (ph_q == PH_SHIFT) begin
                        sh_q <= full_word;
                        if (cnt_q == CNT_W'(WORD_BITS - 1) && full_word[8] && !pend_q) begin
                            ph_q <= PH_SEND;
                            tx_q <= rd_data << (REG_W - int'(cur_len));
                        end
                    end
                end else if (sclk_fall) begin
                    if (ph_q == PH_SEND) begin
                        miso_q <= tx_q[REG_W-1];
                        tx_q   <= {tx_q[REG_W-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign wr_req  = wr_q;
    assign miso    = miso_q;
    assign miso_oe = sel_act;

    // R8
    miso_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !cs_start && !cs_stop) |=> $stable(miso_q));

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_stop && pend_q) |=> !pend_q);

    // R5
    abort_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_stop && cnt_q != CNT_W'(WORD_BITS)) |=> !wr_q.en);

    // R2
    send_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SEND) |-> (cnt_q >= CNT_W'(WORD_BITS) && !pend_q));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          spi_wr,
    input  logic [7:0]       rd_idx,
    output logic [REG_W-1:0] rd_data,
    input  logic             host_we,
    input  logic [7:0]       host_idx,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int g = 0; g < NUM_REGS; g++) begin
                if (spi_wr.en && int'(spi_wr.idx) == g)
                    regs_q[g] <= {{(REG_W-9){1'b0}}, spi_wr.data}
                                 & len_mask(read_len(8'(g), NUM_REGS));
                else if (host_we && int'(host_idx) == g)
                    regs_q[g] <= host_wdata & len_mask(read_len(8'(g), NUM_REGS));
            end
        end
    end

    function automatic logic [REG_W-1:0] pick(input logic [7:0] idx,
                                              input logic [NUM_REGS-1:0][REG_W-1:0] r);
        if (int'(idx) >= NUM_REGS) return '0;
        return r[idx[SEL_W-1:0]];
    endfunction

    assign rd_data    = pick(rd_idx, regs_q);
    assign host_rdata = pick(host_idx, regs_q);

    // R6
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_wr.en && int'(spi_wr.idx) >= NUM_REGS && !host_we) |=> $stable(regs_q));

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    input  logic             host_we,
    input  logic [7:0]       host_idx,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata
);
    logic [2:0]       pins_s;
    logic [7:0]       rd_idx;
    logic [REG_W-1:0] rd_data;
    wr_req_t          wr_req;

    spi_pin_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_mosi, spi_cs_n, spi_sclk}),
        .dout (pins_s)
    );

    spi_frame_ctrl #(.NUM_REGS(NUM_REGS)) frame_i (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[0]),
        .cs_n_s  (pins_s[1]),
        .mosi_s  (pins_s[2]),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_req  (wr_req),
        .miso    (spi_miso),
        .miso_oe (spi_miso_oe)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .spi_wr     (wr_req),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

endmodule

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb_top;
    localparam int NREG = 16;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;
    logic        host_we = 1'b0;
    logic [7:0]  host_idx = '0;
    logic [23:0] host_wdata = '0;
    logic [23:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] model [NREG];

    always #5 clk = ~clk;

    spi_regslave #(.NUM_REGS(NREG)) dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .host_we(host_we),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic int exp_len(input int idx);
        if (idx >= NREG) return 8;
        return (idx % 3 == 0) ? 8 : (idx % 3 == 1) ? 16 : 24;
    endfunction

    function automatic logic [23:0] exp_mask(input int idx);
        return 24'((25'd1 << exp_len(idx)) - 25'd1);
    endfunction

    function automatic logic [23:0] exp_read(input int idx);
        if (idx >= NREG) return '0;
        return model[idx];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [8:0] word, input int nbits, input int nrd,
                        output logic [23:0] rdata);
        rdata = '0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 9) ? word[8-i] : 1'b0;
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        for (int j = 0; j < nrd; j++) begin
            tick(HALF);
            rdata = {rdata[22:0], miso};
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic spi_write(input int idx, input logic [8:0] data);
        logic [23:0] dummy;
        xfer({1'b0, 8'(idx)}, 9, 0, dummy);
        xfer(data, 9, 0, dummy);
        if (idx < NREG) model[idx] = {15'b0, data} & exp_mask(idx);
    endtask

    task automatic spi_read_chk(input string req, input int idx);
        logic [23:0] r;
        xfer({1'b1, 8'(idx)}, 9, exp_len(idx), r);
        check(req, r, exp_read(idx) & exp_mask(idx));
    endtask

    task automatic host_chk(input string req, input int idx);
        host_idx = 8'(idx);
        tick(1);
        check(req, host_rdata, exp_read(idx));
    endtask

    initial begin
        tick(NREG * 0 + 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] r;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        check("R1 oe", {23'b0, miso_oe}, 24'd0);
        for (int i = 0; i < NREG; i++) host_chk("R1 reg", i);

        // R7 enable follows select
        cs_n = 1'b0; tick(6);
        check("R7 oe active", {23'b0, miso_oe}, 24'd1);
        cs_n = 1'b1; tick(6);
        check("R7 oe idle", {23'b0, miso_oe}, 24'd0);

        // R9 parallel writes with masking, then R2 reads of each length
        for (int i = 0; i < NREG; i++) begin
            host_we = 1'b1; host_idx = 8'(i); host_wdata = 24'hA5C300 ^ 24'(i * 24'h010203);
            tick(1);
            host_we = 1'b0;
            model[i] = (24'hA5C300 ^ 24'(i * 24'h010203)) & exp_mask(i);
            host_chk("R9 host write", i);
        end
        spi_read_chk("R2 read 8", 3);
        spi_read_chk("R2 read 16", 4);
        spi_read_chk("R2 read 24", 5);
        spi_read_chk("R8 read 24 msb", 14);

        // R3 write pair
        spi_write(2, 9'h1FF);
        host_chk("R3 write 24", 2);
        spi_write(0, 9'h155);
        host_chk("R3 mask 8", 0);
        spi_read_chk("R3 readback", 0);

        // R6 unmapped
        spi_write(200, 9'h0AB);
        spi_read_chk("R6 read unmapped", 200);
        for (int i = 0; i < NREG; i++) host_chk("R6 no change", i);

        // R4 third frame is an address
        spi_write(7, 9'h033);
        spi_read_chk("R4 after pair", 7);

        // R5 abort in address frame
        xfer({1'b0, 8'd1}, 5, 0, r);
        spi_read_chk("R5 addr abort", 1);
        // R5 abort in data frame after pending address: dropped
        xfer({1'b0, 8'd1}, 9, 0, r);
        xfer(9'h1EE, 6, 0, r);
        host_chk("R5 data abort", 1);
        spi_read_chk("R5 pending dropped", 1);
        // R5 over-long data frame
        xfer({1'b0, 8'd8}, 9, 0, r);
        xfer(9'h0F0, 11, 0, r);
        host_chk("R5 long frame", 8);

        // random mix
        for (int k = 0; k < 70; k++) begin
            int op, idx;
            op  = int'($urandom % 4);
            idx = int'($urandom % 20);
            if (op == 0) begin
                spi_write(idx, 9'($urandom));
                if (idx < NREG) host_chk("R3 random", idx);
            end else if (op == 1) begin
                spi_read_chk("R2 random", idx);
            end else if (op == 2) begin
                int nb;
                nb = int'($urandom % 8) + 1;
                if ($urandom % 2) nb = 10 + int'($urandom % 3);
                xfer({1'b0, 8'(idx)}, 9, 0, r);
                xfer(9'($urandom), nb, 0, r);
                spi_read_chk("R5 random abort", idx % NREG);
            end else begin
                spi_read_chk("R6 random", 16 + (idx % 4));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule